// File: doc/BRIEF.md
# I2C Interface Status Flags

This block keeps the event and status flags of an I2C bus interface as a CPU sees them through its register port. A separate bit engine reports bus events to it as one-cycle strobes: start and stop seen, a byte shifted with its direction, the acknowledge clock completed, own address or general call matched, the first header byte of a 10-bit address sent, arbitration lost and bus error. The CPU side provides read strobes for the two status registers, read and write strobes for the data register, an interrupt enable, an acknowledge enable and the peripheral enable.

The flags are set by hardware events. Most are cleared by a two-step software access: a read of a status register followed by an access to the data register. An armed bit tracks each such sequence. While a byte or address event waits for software, the block requests that the bit engine stretch SCL low. When the interrupt enable is high it also raises an interrupt request. Status register 1 returns the flags in fixed bit positions.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset every flag, the interrupt request and the stretch request are 0.
- R2: Byte-finished (status bit 0) is set on the acknowledge clock strobe that follows a byte-done strobe, or that arrives in the same cycle as one. For a sent byte, transmitter (bit 3) becomes 1. For a received byte, transmitter becomes 0, and the flag is set only if acknowledge enable is 1. Each acknowledge clock uses up the pending byte.
- R3: Byte-finished clears only when a status-1 read made while it is 1 is later followed by a data read or data write. Other accesses in between do not disarm the sequence. A data access with no armed sequence has no effect.
- R4: Transmitter clears together with byte-finished, on stop, on arbitration loss and on disable. It is never 1 while byte-finished is 0.
- R5: The 10-bit header flag (bit 4) is set by the header-sent strobe. It clears only when a status-2 read made while it is 1 is followed by a data write. Data reads and status-1 reads do not complete this clear.
- R6: Address-matched (bit 1) is set by an address match or a general call, and is cleared by a status-1 read.
- R7: Busy (bit 2) is set on start and cleared on stop or bus error, with start taking priority. While the peripheral is disabled, busy holds its value.
- R8: The stretch request equals byte-finished OR address-matched. The interrupt request is that same OR, gated by interrupt enable.
- R9: While enable is 0, byte-finished, transmitter, address-matched, the 10-bit header flag and all armed sequences are held at 0, and set strobes are ignored.
- R10: A hardware set in the same cycle as a clear completion leaves the flag at 1 and uses up the armed sequence.
- R11: Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Peripheral enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| irq_en | input | 1 | Interrupt enable |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_byte_done | input | 1 | Byte shifted |
| ev_byte_tx | input | 1 | Direction of that byte, 1 = sent |
| ev_ack_clk | input | 1 | Acknowledge clock pulse completed |
| ev_addr_match | input | 1 | Own slave address matched |
| ev_gen_call | input | 1 | General call address seen |
| ev_hdr10_sent | input | 1 | First 10-bit header byte sent as master |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Misplaced start or stop |
| rd_st1 | input | 1 | CPU read of status register 1 |
| rd_st2 | input | 1 | CPU read of status register 2 |
| rd_dat | input | 1 | CPU read of the data register |
| wr_dat | input | 1 | CPU write of the data register |
| status | output | 8 | Status register 1 contents |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to stretch SCL low |

## Verification
On every cycle, the assertions check several relations: transmitter never stands without byte-finished; the flags are held clear and busy is frozen while disabled; a status-1 read clears address-matched; a header strobe wins over a completing write; and an interrupt implies a stretch request. Only the bench's scenarios can show the ordered two-step sequences. These include accesses in between that must not disarm, data accesses with nothing armed, the acknowledge-enable gating of received bytes, and set-versus-clear collisions. A behavioural model checks the same behaviour under random strobes.

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ack_en,
  input  logic       irq_en,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte_done,
  input  logic       ev_byte_tx,
  input  logic       ev_ack_clk,
  input  logic       ev_addr_match,
  input  logic       ev_gen_call,
  input  logic       ev_hdr10_sent,
  input  logic       ev_arb_lost,
  input  logic       ev_bus_err,
  input  logic       rd_st1,
  input  logic       rd_st2,
  input  logic       rd_dat,
  input  logic       wr_dat,
  output logic [7:0] status,
  output logic       irq,
  output logic       scl_hold
);

  logic btf, tra, adsl, busy, hdr10;
  logic arm_b, arm_h, pend, pend_tx;

  wire byte_any = pend | ev_byte_done;
  wire byte_dir = ev_byte_done ? ev_byte_tx : pend_tx;
  wire btf_set  = ev_ack_clk & byte_any & (byte_dir | ack_en);
  wire btf_clr  = arm_b & (rd_dat | wr_dat);
  wire hdr_clr  = arm_h & wr_dat;
  wire adsl_set = ev_addr_match | ev_gen_call;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {btf, tra, adsl, busy, hdr10} <= '0;
      {arm_b, arm_h, pend, pend_tx} <= '0;
    end else if (!en) begin
      {btf, tra, adsl, hdr10}       <= '0;
      {arm_b, arm_h, pend, pend_tx} <= '0;
    end else begin
      if (ev_start)                   busy <= 1'b1;
      else if (ev_stop || ev_bus_err) busy <= 1'b0;

      if (ev_ack_clk)        pend <= 1'b0;
      else if (ev_byte_done) {pend, pend_tx} <= {1'b1, ev_byte_tx};

      if (btf_set)      btf <= 1'b1;
      else if (btf_clr) btf <= 1'b0;

      if (btf_set)                                 tra <= byte_dir;
      else if (btf_clr || ev_stop || ev_arb_lost)  tra <= 1'b0;

      if (btf_clr)            arm_b <= 1'b0;
      else if (rd_st1 && btf) arm_b <= 1'b1;

      if (adsl_set)    adsl <= 1'b1;
      else if (rd_st1) adsl <= 1'b0;

      if (ev_hdr10_sent) hdr10 <= 1'b1;
      else if (hdr_clr)  hdr10 <= 1'b0;

      if (hdr_clr)              arm_h <= 1'b0;
      else if (rd_st2 && hdr10) arm_h <= 1'b1;
    end
  end

  assign status   = {3'b000, hdr10, tra, busy, adsl, btf};
  assign scl_hold = btf | adsl;
  assign irq      = irq_en & scl_hold;

  p_tra_with_btf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tra |-> btf);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(btf || tra || adsl || hdr10));

  p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(busy));

  p_st1_read_clears_adsl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_st1 && !ev_addr_match && !ev_gen_call) |=> !status[1]);

  p_hdr_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_hdr10_sent) |=> status[4]);

  p_irq_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_hold);

endmodule

// File: tb/test_i2c_flag_ctrl.sv
`timescale 1ns/1ps
module test_i2c_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ack_en = 0, irq_en = 0;
  logic ev_start = 0, ev_stop = 0, ev_byte_done = 0, ev_byte_tx = 0, ev_ack_clk = 0;
  logic ev_addr_match = 0, ev_gen_call = 0, ev_hdr10_sent = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic rd_st1 = 0, rd_st2 = 0, rd_dat = 0, wr_dat = 0;
  logic [7:0] status;
  logic irq, scl_hold;

  int checks = 0, errors = 0;

  i2c_flag_ctrl i_i2c_flag_ctrl (.*);

  always #2 clk = ~clk;

  // reference model state
  bit m_btf, m_tra, m_adsl, m_busy, m_hdr, m_armb, m_armh, m_pend, m_ptx;

  function automatic logic [7:0] m_status();
    return {3'b000, m_hdr, m_tra, m_busy, m_adsl, m_btf};
  endfunction

  task automatic model_step();
    bit have, dir, setb, clrb, clrh;
    if (!rst_n) begin
      {m_btf, m_tra, m_adsl, m_busy, m_hdr, m_armb, m_armh, m_pend, m_ptx} = '0;
      return;
    end
    if (!en) begin
      {m_btf, m_tra, m_adsl, m_hdr, m_armb, m_armh, m_pend, m_ptx} = '0;
      return;
    end
    have = m_pend || ev_byte_done;
    dir  = ev_byte_done ? ev_byte_tx : m_ptx;
    setb = ev_ack_clk && have && (dir || ack_en);
    clrb = m_armb && (rd_dat || wr_dat);
    clrh = m_armh && wr_dat;
    if (ev_start) m_busy = 1; else if (ev_stop || ev_bus_err) m_busy = 0;
    if (setb) begin m_tra = dir; end
    else if (clrb || ev_stop || ev_arb_lost) m_tra = 0;
    m_armb = clrb ? 0 : (m_armb || (rd_st1 && m_btf));
    m_btf  = setb ? 1 : (clrb ? 0 : m_btf);
    m_armh = clrh ? 0 : (m_armh || (rd_st2 && m_hdr));
    m_hdr  = ev_hdr10_sent ? 1 : (clrh ? 0 : m_hdr);
    m_adsl = (ev_addr_match || ev_gen_call) ? 1 : (rd_st1 ? 0 : m_adsl);
    if (ev_ack_clk) m_pend = 0;
    else if (ev_byte_done) begin m_pend = 1; m_ptx = ev_byte_tx; end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [7:0] e;
    e = m_status();
    chk("R11 model status", status, e);
    chk("R8 model scl_hold", {7'b0, scl_hold}, {7'b0, (m_btf | m_adsl)});
    chk("R8 model irq", {7'b0, irq}, {7'b0, irq_en & (m_btf | m_adsl)});
  endtask

  task automatic clr_strobes();
    {ev_start, ev_stop, ev_byte_done, ev_byte_tx, ev_ack_clk} = '0;
    {ev_addr_match, ev_gen_call, ev_hdr10_sent, ev_arb_lost, ev_bus_err} = '0;
    {rd_st1, rd_st2, rd_dat, wr_dat} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_model();
    clr_strobes();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset outputs", {6'b0, irq, scl_hold}, 8'h00);
    rst_n = 1; en = 1; ack_en = 1; irq_en = 1;
    tick();

    ev_start = 1; tick();
    chk("R7 busy on start", status, 8'h04);

    ev_byte_done = 1; ev_byte_tx = 1; tick();
    chk("R2 no flag before ack clock", status, 8'h04);
    ev_ack_clk = 1; tick();
    chk("R2 sent byte sets btf and tra", status, 8'h0D);
    chk("R8 hold and irq", {6'b0, irq, scl_hold}, 8'h03);

    wr_dat = 1; tick();
    chk("R3 unarmed write ignored", status, 8'h0D);
    rd_st1 = 1; tick();
    rd_st2 = 1; tick();
    chk("R3 still set after arming", status, 8'h0D);
    rd_dat = 1; tick();
    chk("R3 R4 two-step clears btf and tra", status, 8'h04);

    ack_en = 0; ev_byte_done = 1; ev_byte_tx = 0; ev_ack_clk = 1; tick();
    chk("R2 rx without ack does not set", status, 8'h04);
    ev_ack_clk = 1; tick();
    chk("R2 pending used up", status, 8'h04);
    ack_en = 1; ev_byte_done = 1; ev_byte_tx = 0; ev_ack_clk = 1; tick();
    chk("R2 rx with ack sets btf tra=0", status, 8'h05);
    irq_en = 0; tick();
    chk("R8 irq gated", {6'b0, irq, scl_hold}, 8'h01);
    irq_en = 1;
    rd_st1 = 1; tick(); wr_dat = 1; tick();
    chk("R3 write completes clear", status, 8'h04);

    ev_byte_done = 1; ev_byte_tx = 1; ev_ack_clk = 1; tick();
    ev_arb_lost = 1; tick();
    chk("R4 arbitration loss clears tra", status, 8'h05);
    rd_st1 = 1; tick(); rd_dat = 1; tick();
    ev_byte_done = 1; ev_byte_tx = 1; ev_ack_clk = 1; tick();
    ev_stop = 1; tick();
    chk("R4 R7 stop clears tra and busy", status, 8'h01);
    rd_st1 = 1; tick(); rd_dat = 1; tick();
    ev_start = 1; tick();

    ev_addr_match = 1; tick();
    chk("R6 address match", status, 8'h06);
    rd_st1 = 1; tick();
    chk("R6 status read clears", status, 8'h04);
    ev_gen_call = 1; tick();
    chk("R6 general call", status, 8'h06);
    rd_st1 = 1; ev_gen_call = 1; tick();
    chk("R10 set wins over read clear", status, 8'h06);
    rd_st1 = 1; tick();

    ev_hdr10_sent = 1; tick();
    chk("R5 header set", status, 8'h14);
    rd_st2 = 1; tick(); rd_dat = 1; rd_st1 = 1; tick();
    chk("R5 data read does not clear", status, 8'h14);
    wr_dat = 1; tick();
    chk("R5 write completes clear", status, 8'h04);
    ev_hdr10_sent = 1; tick(); rd_st1 = 1; tick(); wr_dat = 1; tick();
    chk("R5 status-1 read does not arm", status, 8'h14);
    rd_st2 = 1; tick(); wr_dat = 1; ev_hdr10_sent = 1; tick();
    chk("R10 header set wins", status, 8'h14);
    wr_dat = 1; tick();
    chk("R10 arm used up", status, 8'h14);
    rd_st2 = 1; tick(); wr_dat = 1; tick();

    ev_byte_done = 1; ev_byte_tx = 1; ev_ack_clk = 1; tick();
    rd_st1 = 1; tick();
    ev_byte_done = 1; ev_byte_tx = 1; ev_ack_clk = 1; rd_dat = 1; tick();
    chk("R10 btf set wins", status, 8'h0D);
    rd_dat = 1; tick();
    chk("R3 R10 arm consumed", status, 8'h0D);
    ev_addr_match = 1; ev_hdr10_sent = 1; tick();
    chk("R11 all flags set, unused zero", status, 8'h1F);

    en = 0; tick();
    chk("R9 disable clears, busy kept", status, 8'h04);
    ev_stop = 1; ev_addr_match = 1; ev_hdr10_sent = 1; tick();
    chk("R7 R9 frozen and ignored", status, 8'h04);
    en = 1; tick();
    rd_dat = 1; wr_dat = 1; tick();
    chk("R9 arms dropped by disable", status, 8'h04);
    ev_bus_err = 1; tick();
    chk("R7 bus error clears busy", status, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      en = ($urandom_range(0, 19) != 0);
      ack_en = $urandom_range(0, 1);
      irq_en = $urandom_range(0, 1);
      ev_start = ($urandom_range(0, 9) == 0);
      ev_stop = ($urandom_range(0, 11) == 0);
      ev_byte_done = ($urandom_range(0, 4) == 0);
      ev_byte_tx = $urandom_range(0, 1);
      ev_ack_clk = ($urandom_range(0, 4) == 0);
      ev_addr_match = ($urandom_range(0, 12) == 0);
      ev_gen_call = ($urandom_range(0, 20) == 0);
      ev_hdr10_sent = ($urandom_range(0, 12) == 0);
      ev_arb_lost = ($urandom_range(0, 15) == 0);
      ev_bus_err = ($urandom_range(0, 25) == 0);
      rd_st1 = ($urandom_range(0, 3) == 0);
      rd_st2 = ($urandom_range(0, 3) == 0);
      rd_dat = ($urandom_range(0, 3) == 0);
      wr_dat = ($urandom_range(0, 3) == 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule